// File: doc/BRIEF.md
# Programmable Tapped Delay Line

This block delays a single-bit signal by a number of clock cycles picked by a 6-bit select code. The delay is a fixed base latency plus the code times a per-step cycle count, so the 64 codes give 64 evenly spaced, strictly increasing delays. The line drives a true output and a complementary output. An active-low enable forces the true output low and the complementary output high while it is deasserted. During that time the line keeps shifting.

The select code is used as it is at every clock edge and is never held in a register for the data path, so a code change moves the output tap at once. A move to a longer delay exposes older samples that still sit in the line, and a re-enable can release edges captured before the disable. A `settled` status output shows when neither of these hazards is pending. It is low while a window opened by a code increase, or a window opened by a disable, is still counting down.

Top module: `prog_delay_line`

## Requirements
- R1: With D = BASE_CYCLES + code × STEP_CYCLES, and with enable asserted (en_n low) at edge n, `dout` after clock edge n equals `din` as sampled at edge n − D + 1. The code is the unsigned 6-bit value on `code`, from 0 to 63.
- R2: The delay is monotonic. A single pulse on `din` first shows on `dout` after exactly D edges, counting its capture edge as the first, and each code step adds exactly STEP_CYCLES.
- R3: The code is not latched. The tap used at edge n is given by `code` sampled at that same edge, including the first edge after a change.
- R4: `dout_n` is always the complement of `dout`.
- R5: If `en_n` is sampled high at an edge, then after that edge `dout` is 0 and `dout_n` is 1. The line keeps shifting, so once enable returns the output again follows R1.
- R6: If `code` sampled at an edge exceeds the value sampled at the previous edge by delta, `settled` is low for delta × STEP_CYCLES cycles after that edge. A decrease or an unchanged code opens no window.
- R7: While `en_n` is high, `settled` rises after the edge that takes the W-th consecutive sample of `din` low, with W = code × STEP_CYCLES. The count starts at the first disabled edge, or starts again after the last high `din` sample. A high `din` sample while disabled sets `settled` low for W more cycles. With code 0 no window opens.
- R8: A synchronous active-high `rst` clears the line to all zeros and sets `dout` = 0, `dout_n` = 1 and `settled` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Signal to delay |
| code | input | 6 | Delay select, used unlatched |
| en_n | input | 1 | Active-low output enable |
| dout | output | 1 | Delayed signal (registered) |
| dout_n | output | 1 | Complement of dout (registered) |
| settled | output | 1 | High when no stale edge can appear (registered) |

## Verification
A `din` value captured at edge n is due on `dout` after edge n + D − 1. The bench keeps a history indexed by edge number and compares one cycle after each edge against the entry D − 1 edges back, using the code driven for that same edge. Enable forcing and the opening of a `settled` window both take effect after the very edge that samples their cause. A window of W cycles closes after edge n + W, and the bench samples `settled` after each edge of the window and expects its rise after exactly that edge. Pulse latency is measured for every code by counting edges from the capture edge to the first high `dout`.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int CODE_W   = 6;
  localparam int MAX_CODE = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] code_t;

  // register stages behind the input needed for the longest delay
  function automatic int line_depth(input int step, input int base);
    return base + MAX_CODE * step - 1;
  endfunction

  function automatic int win_width(input int step);
    return $clog2(MAX_CODE * step + 1);
  endfunction
endpackage

// File: rtl/dl_shift_line.sv
module dl_shift_line
  import dl_pkg::*;
#(
  parameter int STEP_CYCLES = 2,
  parameter int BASE_CYCLES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  din,
  input  code_t code,
  output logic  tap_out
);
  localparam int DEPTH = line_depth(STEP_CYCLES, BASE_CYCLES);
  localparam int IW    = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] stage;
  logic [DEPTH:0]   taps;
  logic [IW-1:0]    idx;

  // one flop per stage; stage[0] takes the input
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= 1'b0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign taps = {stage, din};

  // tap 0 is the live input; output register adds the last cycle
  always_comb begin
    idx     = IW'(BASE_CYCLES - 1) + IW'(code) * IW'(STEP_CYCLES);
    tap_out = taps[idx];
  end
endmodule

// File: rtl/dl_out_stage.sv
module dl_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic tap_in,
  input  logic en_n,
  output logic dout,
  output logic dout_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= 1'b0;
      dout_n <= 1'b1;
    end else if (en_n) begin
      dout   <= 1'b0;
      dout_n <= 1'b1;
    end else begin
      dout   <= tap_in;
      dout_n <= ~tap_in;
    end
  end
endmodule

// File: rtl/dl_flush_tracker.sv
module dl_flush_tracker
  import dl_pkg::*;
#(
  parameter int STEP_CYCLES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  din,
  input  code_t code,
  input  logic  en_n,
  output logic  settled
);
  localparam int WW = win_width(STEP_CYCLES);

  code_t         code_q;
  logic          dis_q;
  logic [WW-1:0] chg_rem, chg_nxt, chg_dec, inc_win;
  logic [WW-1:0] dis_rem, dis_nxt, dis_dec, full_win;

  always_comb begin
    inc_win  = (code > code_q) ? WW'(code - code_q) * WW'(STEP_CYCLES) : '0;
    chg_dec  = (chg_rem == '0) ? '0 : chg_rem - 1'b1;
    chg_nxt  = (inc_win > chg_dec) ? inc_win : chg_dec;

    full_win = WW'(code) * WW'(STEP_CYCLES);
    dis_dec  = (dis_rem == '0) ? '0 : dis_rem - 1'b1;
    if (en_n && din)
      dis_nxt = full_win;
    else if (en_n && !dis_q)
      dis_nxt = (full_win == '0) ? '0 : full_win - 1'b1;
    else
      dis_nxt = dis_dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= code;
      dis_q   <= 1'b0;
      chg_rem <= '0;
      dis_rem <= '0;
      settled <= 1'b1;
    end else begin
      code_q  <= code;
      dis_q   <= en_n;
      chg_rem <= chg_nxt;
      dis_rem <= dis_nxt;
      settled <= (chg_nxt == '0) && (dis_nxt == '0);
    end
  end
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import dl_pkg::*;
#(
  parameter int STEP_CYCLES = 2,
  parameter int BASE_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [5:0] code,
  input  logic       en_n,
  output logic       dout,
  output logic       dout_n,
  output logic       settled
);
  logic tap;

  dl_shift_line #(
    .STEP_CYCLES(STEP_CYCLES),
    .BASE_CYCLES(BASE_CYCLES)
  ) u_line (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .code   (code),
    .tap_out(tap)
  );

  dl_out_stage u_out (
    .clk   (clk),
    .rst   (rst),
    .tap_in(tap),
    .en_n  (en_n),
    .dout  (dout),
    .dout_n(dout_n)
  );

  dl_flush_tracker #(
    .STEP_CYCLES(STEP_CYCLES)
  ) u_flush (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .code   (code),
    .en_n   (en_n),
    .settled(settled)
  );
endmodule

// File: rtl/dl_checker.sv
module dl_checker (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic [5:0] code,
  input logic       en_n,
  input logic       dout,
  input logic       dout_n,
  input logic       settled
);
  // R4: the two outputs never agree
  a_r4_outputs_complementary: assert property (
    @(posedge clk) disable iff (rst) dout_n == !dout);

  // R5: disabled sample forces fixed levels after the edge
  a_r5_disable_forces_levels: assert property (
    @(posedge clk) disable iff (rst) en_n |=> (!dout && dout_n));

  // R6: a code increase opens a window at once
  a_r6_increase_opens_window: assert property (
    @(posedge clk) disable iff (rst) (code > $past(code)) |=> !settled);

  // R7: active input while disabled keeps the line unclear
  a_r7_busy_input_holds_window: assert property (
    @(posedge clk) disable iff (rst) (en_n && din && code != 6'd0) |=> !settled);

  // R8: reset state
  a_r8_reset_state: assert property (
    @(posedge clk) rst |=> (!dout && dout_n && settled));
endmodule

bind prog_delay_line dl_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .din    (din),
  .code   (code),
  .en_n   (en_n),
  .dout   (dout),
  .dout_n (dout_n),
  .settled(settled)
);

// File: tb/prog_delay_line_test.sv
`timescale 1ns/1ps
module prog_delay_line_test;
  localparam int STEP = 2;
  localparam int BASE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [5:0] code = 6'd0;
  logic       en_n = 1'b0;
  logic       dout, dout_n, settled;

  int   errors = 0;
  int   checks = 0;
  int   edge_n = 200;
  bit   done = 0;
  logic hist [0:32767];
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  prog_delay_line #(.STEP_CYCLES(STEP), .BASE_CYCLES(BASE)) uut (
    .clk(clk), .rst(rst), .din(din), .code(code), .en_n(en_n),
    .dout(dout), .dout_n(dout_n), .settled(settled));

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (edge %0d)", req, what, act, exp, edge_n);
    end
  endtask

  task automatic tick(input logic d, input logic [5:0] c, input logic e);
    @(negedge clk);
    din = d; code = c; en_n = e;
    edge_n++;
    hist[edge_n] = rst ? 1'b0 : d;
    @(posedge clk);
    #1;
  endtask

  task automatic check_line(input string req);
    int   dl;
    logic e;
    dl = BASE + int'(code) * STEP;
    e  = en_n ? 1'b0 : hist[edge_n - dl + 1];
    chk(req, int'(dout), int'(e), "dout");
    chk("R4", int'(dout_n), int'(!e), "dout_n");
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1'b1, code, 1'b0);
    tick(1'b1, code, 1'b0);
    chk("R8", int'(dout), 0, "dout in reset");
    chk("R8", int'(dout_n), 1, "dout_n in reset");
    chk("R8", int'(settled), 1, "settled in reset");
    for (int i = edge_n - 199; i <= edge_n; i++) hist[i] = 1'b0;
    rst = 1'b0;
  endtask

  function automatic void step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  initial begin
    int prev, meas, dl;
    bit found;
    for (int i = 0; i <= 32767; i++) hist[i] = 1'b0;
    do_reset();

    // sweep every code: flush, pulse latency, random traffic
    prev = 0;
    for (int c = 0; c <= 63; c++) begin
      dl = BASE + c * STEP;
      for (int t = 0; t < dl + 2; t++) begin
        tick(1'b0, 6'(c), 1'b0);
        check_line(t < 4 ? "R3" : "R1");
      end
      found = 0; meas = 0;
      for (int t = 1; t <= dl + 4; t++) begin
        tick(t == 1, 6'(c), 1'b0);
        check_line("R1");
        if (!found && dout) begin found = 1; meas = t; end
      end
      chk("R2", meas, dl, "pulse latency");
      if (c > 0) chk("R2", meas - prev, STEP, "latency step");
      prev = meas;
      for (int t = 0; t < 40; t++) begin
        step_lfsr();
        tick(lfsr[0], 6'(c), lfsr[4:1] == 4'd0);
        check_line(en_n ? "R5" : "R1");
      end
    end

    // R6: increase window, then decrease
    for (int t = 0; t < 140; t++) tick(1'b0, 6'd5, 1'b0);
    chk("R6", int'(settled), 1, "settled before increase");
    for (int k = 0; k <= 8; k++) begin
      tick(1'b0, 6'd9, 1'b0);
      chk("R6", int'(settled), (k >= 8) ? 1 : 0, "settled after 5->9");
    end
    tick(1'b0, 6'd3, 1'b0);
    chk("R6", int'(settled), 1, "settled after decrease");

    // R7: disable window, code 4 -> W = 8
    for (int t = 0; t < 140; t++) tick(1'b0, 6'd4, 1'b0);
    for (int k = 1; k <= 8; k++) begin
      tick(1'b0, 6'd4, 1'b1);
      chk("R7", int'(settled), (k >= 8) ? 1 : 0, "settled disabled low");
      chk("R5", int'(dout), 0, "dout disabled");
      chk("R5", int'(dout_n), 1, "dout_n disabled");
    end
    for (int t = 0; t < 140; t++) tick(1'b0, 6'd4, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      tick(1'b0, 6'd4, 1'b1);
      chk("R7", int'(settled), 0, "settled early disable");
    end
    tick(1'b1, 6'd4, 1'b1);
    chk("R7", int'(settled), 0, "settled after high sample");
    for (int k = 1; k <= 8; k++) begin
      tick(1'b0, 6'd4, 1'b1);
      chk("R7", int'(settled), (k >= 8) ? 1 : 0, "settled restarted window");
    end
    // code 0: no window
    for (int t = 0; t < 140; t++) tick(1'b0, 6'd0, 1'b0);
    tick(1'b1, 6'd0, 1'b1);
    chk("R7", int'(settled), 1, "settled code 0 disable");

    // R8: reset mid-stream with ones in the line
    for (int t = 0; t < 60; t++) begin tick(1'b1, 6'd20, 1'b0); check_line("R1"); end
    do_reset();
    for (int t = 0; t < 45; t++) begin tick(1'b0, 6'd20, 1'b0); check_line("R8"); end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule